// File: doc/BRIEF.md
# Four-State Snooping Cache Controller

This block is the coherence engine for one processor's private, direct-mapped, write-back cache on a shared atomic bus. Each cache line is Modified, Exclusive, Shared or Invalid. Processor loads and stores hit locally when the line state allows. Otherwise the controller requests the bus and, once granted, performs a single-cycle transaction: a fetch for reading, a fetch-for-ownership, or a write-back of a dirty victim. Every line is one data word.

In every cycle in which another agent owns the bus, the controller looks up the snooped address. If it holds a copy, it drives its contribution to a wired-OR shared line. If its copy is dirty, it drives the data onto the bus, and it demotes or invalidates its own copy as the transaction requires. When clean cache-to-cache supply is enabled, a priority chain through the holders makes sure that exactly one clean holder drives the data. The system around the controller supplies four things: an arbiter that grants one requester per cycle, the OR of the shared outputs, the data mux (flushed or supplied data before memory), and a memory that stores flushed and written-back data.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: A read that misses raises `bus_req_o`. When granted, the controller issues a fetch (bus command code 1). The line becomes Exclusive if `bus_shared_i` was low in that cycle and Shared if it was high, and `cpu_rdata` returns the bus data.
- R2: A write to a line that is Invalid, absent or Shared issues a fetch-for-ownership (command code 2) and leaves the line Modified, holding the write data.
- R3: A write to an Exclusive line makes it Modified without any bus transaction.
- R4: Reads to valid lines and writes to Modified lines complete without any bus transaction, returning `cpu_ready` in the cycle after the request is accepted.
- R5: On a snooped fetch (code 1) to a Modified line, the controller drives `snp_flush_o` with the line data and moves the line to Shared. A snooped fetch to an Exclusive line also moves it to Shared.
- R6: On a snooped fetch-for-ownership (code 2), any valid copy becomes Invalid. A Modified copy drives `snp_flush_o` with its data first.
- R7: Every controller that holds the snooped block in a valid state raises `snp_shared_o` during a snooped fetch, and only then.
- R8: With `C2C_EN`=1, a clean holder (Shared or Exclusive) drives `snp_supply_o` on a snooped fetch only if `sup_chain_i` is low. `sup_chain_o` passes the chain on, so exactly one clean holder supplies the data.
- R9: A miss whose victim line is Modified with a different tag first writes the victim back (command code 3, victim address and data), then issues the fetch. A clean victim is dropped without a write-back.
- R10: `cpu_ready` is a one-cycle pulse. Bus commands other than 0 appear only while `bus_gnt_i` is high, and `bus_req_o` falls after the final transaction of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, all lines Invalid |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address, low IDX_W bits index the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request complete pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Grant, this cycle is the own transaction |
| bus_cmd_o | output | 2 | Own command: 0 none, 1 fetch, 2 fetch-for-ownership, 3 write-back |
| bus_addr_o | output | ADDR_W | Own transaction address |
| bus_data_o | output | DATA_W | Write-back data |
| bus_valid_i | input | 1 | A transaction is on the bus |
| bus_cmd_i | input | 2 | Command on the bus |
| bus_addr_i | input | ADDR_W | Address on the bus |
| bus_data_i | input | DATA_W | Data returned on the bus |
| bus_shared_i | input | 1 | Wired-OR shared line |
| snp_shared_o | output | 1 | This cache holds the snooped block |
| snp_flush_o | output | 1 | Driving dirty data |
| snp_supply_o | output | 1 | Driving clean data |
| snp_data_o | output | DATA_W | Data driven for flush or supply |
| sup_chain_i | input | 1 | An earlier holder already supplies |
| sup_chain_o | output | 1 | Chain onward |

## Verification
The bench builds three controllers with 8-bit addresses, 16-bit data, four lines and clean supply enabled, chained in index order on a round-robin bus. Three caches are enough to have two clean holders at once, which exercises the supply chain and a shared count of two. Addresses 0x10 and 0x30 share index 0, so conflict evictions of both dirty and clean victims come within reach. Because the bench counts bus transactions per request, Exclusive and Shared fills can be told apart at the ports: a following store costs zero transactions after an Exclusive fill and one after a Shared fill.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_WB = 2'd3} bus_cmd_t;

  // state after observing another agent's transaction
  function automatic line_st_t snoop_next(line_st_t s, bus_cmd_t c);
    if (c == BC_RDX) return LN_I;
    if (c == BC_RD && (s == LN_M || s == LN_E)) return LN_S;
    return s;
  endfunction

  // state after an own fetch, chosen by the shared line
  function automatic line_st_t fill_state(logic shared_seen);
    return shared_seen ? LN_S : LN_E;
  endfunction

  function automatic logic is_valid(line_st_t s);
    return s != LN_I;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wa_en,
  input  line_st_t          wa_st,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  line_st_t          wb_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

  // port A (own side, full line) and port B (snoop, state only) never hit one index together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LN_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (wa_en) begin
        st_q[a_idx]   <= wa_st;
        tag_q[a_idx]  <= wa_tag;
        data_q[a_idx] <= wa_data;
      end
      if (wb_en) st_q[b_idx] <= wb_st;
    end
  end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int C2C_EN = 1
) (
  input  logic     act,
  input  bus_cmd_t cmd,
  input  line_st_t st,
  input  logic     tag_eq,
  input  logic     sup_in,
  output logic     hit,
  output logic     shared,
  output logic     flush,
  output logic     supply,
  output logic     sup_out,
  output logic     st_wr,
  output line_st_t st_nxt
);
  assign hit     = act && tag_eq && is_valid(st) && (cmd == BC_RD || cmd == BC_RDX);
  assign shared  = hit && cmd == BC_RD;
  assign flush   = hit && st == LN_M;
  assign st_nxt  = snoop_next(st, cmd);
  assign st_wr   = hit && st_nxt != st;
  assign sup_out = sup_in || supply;

  generate
    if (C2C_EN != 0) begin : g_c2c
      assign supply = shared && (st == LN_S || st == LN_E) && !sup_in;
    end else begin : g_mem_only
      assign supply = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int C2C_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_valid_i,
  input  logic [1:0]        bus_cmd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_shared_i,
  output logic              snp_shared_o,
  output logic              snp_flush_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o,
  input  logic              sup_chain_i,
  output logic              sup_chain_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_BUS, F_DONE} fsm_t;

  fsm_t              fsm_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic              rq_we_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // own-side lookup
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  c_idx;
  line_st_t          c_st;
  logic [TAG_W-1:0]  c_tag;
  logic [DATA_W-1:0] c_data;
  logic              tag_match;

  // snoop-side lookup
  logic [IDX_W-1:0]  s_idx;
  line_st_t          s_st;
  logic [TAG_W-1:0]  s_tag;
  logic [DATA_W-1:0] s_data;
  logic              snp_act, snp_hit, snp_wr;
  line_st_t          snp_nxt;

  // named events
  logic cpu_accept, cpu_hit_rd, cpu_hit_wr, cpu_hit_local, silent_upgrade, cpu_miss;
  logic granted, evict, fetch;

  line_st_t          wa_st;
  logic [TAG_W-1:0]  wa_tag;
  logic [DATA_W-1:0] wa_data;
  logic              wa_en;

  assign look_addr = (fsm_q == F_IDLE) ? cpu_addr : rq_addr_q;
  assign c_idx     = look_addr[IDX_W-1:0];
  assign tag_match = c_tag == look_addr[ADDR_W-1:IDX_W];

  assign s_idx   = bus_addr_i[IDX_W-1:0];
  assign snp_act = bus_valid_i && !bus_gnt_i;

  // a local access to the index being snooped waits one cycle
  assign cpu_accept     = fsm_q == F_IDLE && cpu_req && !(snp_act && s_idx == c_idx);
  assign cpu_hit_rd     = cpu_accept && !cpu_we && tag_match && is_valid(c_st);
  assign cpu_hit_wr     = cpu_accept && cpu_we && tag_match && (c_st == LN_M || c_st == LN_E);
  assign silent_upgrade = cpu_hit_wr && c_st == LN_E;
  assign cpu_hit_local  = cpu_hit_rd || cpu_hit_wr;
  assign cpu_miss       = cpu_accept && !cpu_hit_local;

  assign granted = fsm_q == F_BUS && bus_gnt_i;
  assign evict   = granted && c_st == LN_M && !tag_match;
  assign fetch   = granted && !evict;

  assign bus_req_o  = fsm_q == F_BUS;
  assign bus_cmd_o  = evict ? BC_WB : (fetch ? (rq_we_q ? BC_RDX : BC_RD) : BC_NONE);
  assign bus_addr_o = evict ? {c_tag, rq_addr_q[IDX_W-1:0]} : rq_addr_q;
  assign bus_data_o = c_data;
  assign cpu_ready  = fsm_q == F_DONE;
  assign cpu_rdata  = rdata_q;

  always_comb begin
    wa_en   = cpu_hit_wr || granted;
    wa_st   = LN_M;
    wa_tag  = look_addr[ADDR_W-1:IDX_W];
    wa_data = cpu_wdata;
    if (evict) begin
      wa_st   = LN_I;
      wa_tag  = c_tag;
      wa_data = c_data;
    end else if (fetch) begin
      wa_st   = rq_we_q ? LN_M : fill_state(bus_shared_i);
      wa_data = rq_we_q ? rq_wdata_q : bus_data_i;
    end
  end

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(c_idx), .a_st(c_st), .a_tag(c_tag), .a_data(c_data),
    .b_idx(s_idx), .b_st(s_st), .b_tag(s_tag), .b_data(s_data),
    .wa_en(wa_en), .wa_st(wa_st), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(snp_wr), .wb_st(snp_nxt)
  );

  mesi_snoop_resp #(.C2C_EN(C2C_EN)) u_snoop (
    .act(snp_act), .cmd(bus_cmd_t'(bus_cmd_i)), .st(s_st),
    .tag_eq(s_tag == bus_addr_i[ADDR_W-1:IDX_W]), .sup_in(sup_chain_i),
    .hit(snp_hit), .shared(snp_shared_o), .flush(snp_flush_o),
    .supply(snp_supply_o), .sup_out(sup_chain_o), .st_wr(snp_wr), .st_nxt(snp_nxt)
  );

  assign snp_data_o = s_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q      <= F_IDLE;
      rq_addr_q  <= '0;
      rq_we_q    <= 1'b0;
      rq_wdata_q <= '0;
      rdata_q    <= '0;
    end else begin
      case (fsm_q)
        F_IDLE: begin
          if (cpu_accept) begin
            rq_addr_q  <= cpu_addr;
            rq_we_q    <= cpu_we;
            rq_wdata_q <= cpu_wdata;
            rdata_q    <= c_data;
            fsm_q      <= cpu_hit_local ? F_DONE : F_BUS;
          end
        end
        F_BUS: begin
          if (fetch) begin
            rdata_q <= rq_we_q ? rq_wdata_q : bus_data_i;
            fsm_q   <= F_DONE;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_chk.sv
module mesi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic       bus_req_o,
  input logic       bus_gnt_i,
  input logic [1:0] bus_cmd_o,
  input logic       bus_valid_i,
  input logic [1:0] bus_cmd_i,
  input logic       snp_shared_o,
  input logic       snp_flush_o,
  input logic       snp_supply_o,
  input logic       sup_chain_i,
  input logic       sup_chain_o,
  input logic       cpu_hit_local,
  input logic       silent_upgrade,
  input logic       cpu_miss
);
  p_miss_requests_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_miss |=> bus_req_o);
  p_silent_upgrade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    silent_upgrade |=> cpu_ready && !bus_req_o);
  p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit_local |=> cpu_ready && !bus_req_o);
  p_flush_on_snoop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush_o |-> bus_valid_i && !bus_gnt_i && (bus_cmd_i == 2'd1 || bus_cmd_i == 2'd2));
  p_shared_on_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_o |-> bus_valid_i && !bus_gnt_i && bus_cmd_i == 2'd1);
  p_single_supplier_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply_o |-> !sup_chain_i && !snp_flush_o);
  p_chain_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sup_chain_i |-> sup_chain_o);
  p_evict_then_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt_i && bus_cmd_o == 2'd3) |=> bus_req_o);
  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  p_cmd_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_o != 2'd0 |-> bus_gnt_i);
endmodule

bind snoop_cache_ctrl mesi_chk u_mesi_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req_o(bus_req_o),
  .bus_gnt_i(bus_gnt_i), .bus_cmd_o(bus_cmd_o), .bus_valid_i(bus_valid_i),
  .bus_cmd_i(bus_cmd_i), .snp_shared_o(snp_shared_o), .snp_flush_o(snp_flush_o),
  .snp_supply_o(snp_supply_o), .sup_chain_i(sup_chain_i), .sup_chain_o(sup_chain_o),
  .cpu_hit_local(cpu_hit_local), .silent_upgrade(silent_upgrade), .cpu_miss(cpu_miss)
);

// File: tb/test_snoop_cache_ctrl.sv
module test_snoop_cache_ctrl;
  localparam int N  = 3;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          c_req   [N];
  logic          c_we    [N];
  logic [AW-1:0] c_addr  [N];
  logic [DW-1:0] c_wdata [N];
  logic [DW-1:0] c_rdata [N];
  logic [1:0]    cmd_o   [N];
  logic [AW-1:0] addr_o  [N];
  logic [DW-1:0] dat_o   [N];
  logic [DW-1:0] snp_d   [N];
  logic [N-1:0]  rdy_v, req_v, gnt_v, shr_v, fl_v, sup_v;
  logic [N:0]    chain;

  logic          bus_valid;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wb_data, bus_data, flush_data, sup_data;
  logic          bus_shared;
  int            win;
  int            rr_q;
  logic [DW-1:0] mem [256];

  function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
    return DW'(a) * 16'd3 + 16'd1;
  endfunction

  assign chain[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_cpu
    snoop_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2), .C2C_EN(1)) i_snoop_cache_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(c_req[k]), .cpu_we(c_we[k]), .cpu_addr(c_addr[k]), .cpu_wdata(c_wdata[k]),
      .cpu_ready(rdy_v[k]), .cpu_rdata(c_rdata[k]),
      .bus_req_o(req_v[k]), .bus_gnt_i(gnt_v[k]), .bus_cmd_o(cmd_o[k]),
      .bus_addr_o(addr_o[k]), .bus_data_o(dat_o[k]),
      .bus_valid_i(bus_valid), .bus_cmd_i(bus_cmd), .bus_addr_i(bus_addr),
      .bus_data_i(bus_data), .bus_shared_i(bus_shared),
      .snp_shared_o(shr_v[k]), .snp_flush_o(fl_v[k]), .snp_supply_o(sup_v[k]),
      .snp_data_o(snp_d[k]), .sup_chain_i(chain[k]), .sup_chain_o(chain[k+1])
    );
  end

  // round-robin arbiter and bus muxes
  always_comb begin
    gnt_v = '0;
    win   = 0;
    for (int j = 0; j < N; j++) begin
      int k;
      k = (rr_q + j) % N;
      if (gnt_v == '0 && req_v[k]) begin
        gnt_v[k] = 1'b1;
        win      = k;
      end
    end
    bus_valid   = gnt_v != '0;
    bus_cmd     = cmd_o[win];
    bus_addr    = addr_o[win];
    bus_wb_data = dat_o[win];
    bus_shared  = |shr_v;
    flush_data  = '0;
    sup_data    = '0;
    for (int j = 0; j < N; j++) begin
      if (fl_v[j])  flush_data = snp_d[j];
      if (sup_v[j]) sup_data   = snp_d[j];
    end
    // a flushing cache cancels the memory response
    bus_data = (|fl_v) ? flush_data : ((|sup_v) ? sup_data : mem[bus_addr]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= init_val(AW'(i));
    end else if (bus_valid) begin
      rr_q <= (win + 1) % N;
      if (bus_cmd == 2'd3) mem[bus_addr] <= bus_wb_data;
      else if (|fl_v)      mem[bus_addr] <= flush_data;
    end
  end

  // scoreboard state
  typedef struct {
    int            cpu;
    logic [DW-1:0] val;
    string         rq;
  } exp_t;
  exp_t          sb_q [$];
  logic [DW-1:0] gold [256];
  int            checks = 0;
  int            fails = 0;
  int            txn_cnt = 0;
  logic [1:0]    cmd_log [64];
  int            shr_last = 0;
  int            sup_last = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: bus transactions and read results
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_valid) begin
        cmd_log[txn_cnt % 64] = bus_cmd;
        shr_last = $countones(shr_v);
        sup_last = $countones(sup_v);
        txn_cnt++;
      end
      for (int p = 0; p < N; p++) begin
        if (rst_n && rdy_v[p] && sb_q.size() > 0 && sb_q[0].cpu == p) begin
          exp_t e;
          e = sb_q.pop_front();
          chk(c_rdata[p] == e.val, e.rq, int'(c_rdata[p]), int'(e.val));
        end
      end
    end
  end

  task automatic op(input int p, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int exp_txn, input logic [1:0] exp_first, input string rq);
    int base;
    @(negedge clk);
    if (!we) begin
      exp_t e;
      e.cpu = p;
      e.val = gold[a];
      e.rq  = rq;
      sb_q.push_back(e);
    end else begin
      gold[a] = d;
    end
    base       = txn_cnt;
    c_req[p]   = 1'b1;
    c_we[p]    = we;
    c_addr[p]  = a;
    c_wdata[p] = d;
    do @(negedge clk); while (!rdy_v[p]);
    c_req[p] = 1'b0;
    chk(txn_cnt - base == exp_txn, {rq, " bus transactions"}, txn_cnt - base, exp_txn);
    if (exp_txn > 0)
      chk(cmd_log[base % 64] == exp_first, {rq, " first command"},
          int'(cmd_log[base % 64]), int'(exp_first));
    @(negedge clk);
    chk(rdy_v[p] == 1'b0 && req_v[p] == 1'b0, "R10 ready pulse and request drop",
        int'({rdy_v[p], req_v[p]}), 0);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      c_req[p] = 1'b0; c_we[p] = 1'b0; c_addr[p] = '0; c_wdata[p] = '0;
    end
    for (int i = 0; i < 256; i++) gold[i] = init_val(AW'(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_v == '0 && req_v == '0 && txn_cnt == 0, "R10 reset state", int'({rdy_v, req_v}), 0);

    op(0, 0, 8'h10, 16'h0,    1, 2'd1, "R1 read miss fills");
    op(0, 1, 8'h10, 16'hAAAA, 0, 2'd0, "R3 exclusive write silent");
    op(0, 0, 8'h10, 16'h0,    0, 2'd0, "R4 modified read hit");
    op(1, 0, 8'h10, 16'h0,    1, 2'd1, "R5 fetch flushes modified");
    chk(shr_last == 1, "R7 one holder shares", shr_last, 1);
    op(1, 1, 8'h10, 16'hBBBB, 1, 2'd2, "R2 shared write takes ownership");
    op(0, 0, 8'h10, 16'h0,    1, 2'd1, "R5 invalidated reader refetches");
    op(2, 1, 8'h10, 16'hCCCC, 1, 2'd2, "R2 invalid write takes ownership");
    op(0, 0, 8'h10, 16'h0,    1, 2'd1, "R6 ownership invalidates and flushes");
    op(1, 0, 8'h10, 16'h0,    1, 2'd1, "R6 second reader refetches");
    chk(shr_last == 2, "R7 two holders share", shr_last, 2);
    chk(sup_last == 1, "R8 one clean supplier", sup_last, 1);
    op(0, 1, 8'h10, 16'hDDDD, 1, 2'd2, "R1 shared fill forces upgrade");
    op(1, 0, 8'h21, 16'h0,    1, 2'd1, "R1 unshared read miss");
    chk(sup_last == 0 && shr_last == 0, "R8 no holder no supply", sup_last + shr_last, 0);
    op(2, 0, 8'h21, 16'h0,    1, 2'd1, "R5 exclusive holder snooped");
    chk(sup_last == 1, "R8 exclusive holder supplies", sup_last, 1);
    op(1, 1, 8'h21, 16'h1111, 1, 2'd2, "R5 exclusive demoted to shared");
    op(0, 0, 8'h30, 16'h0,    2, 2'd3, "R9 dirty victim written back");
    chk(cmd_log[(txn_cnt - 1) % 64] == 2'd1, "R9 fetch after write-back",
        int'(cmd_log[(txn_cnt - 1) % 64]), 1);
    op(2, 0, 8'h10, 16'h0,    1, 2'd1, "R9 memory holds written-back data");
    op(2, 0, 8'h30, 16'h0,    1, 2'd1, "R9 clean victim dropped");
    op(0, 1, 8'h30, 16'h2222, 1, 2'd2, "R7 shared by later reader");
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R1 all reads returned", sb_q.size(), 0);
    summary();
    $finish;
  end
endmodule